// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the card bus clock from the peripheral clock, which is the only clock in the design. Software programs a 16-bit rate word made of two fields. A 4-bit divider field `D` sits in bits [3:0], and a prescaler field `P` sits in bits [15:4]. The overall division ratio is `D+1` when `P` is zero. Otherwise it is `(D+1)·2·P`. This gives outputs from the peripheral rate divided by 2 down to the peripheral rate divided by 65536, where `P` is 0 or a power of two no larger than 0x800.

A control word starts or stops the clock and can request a soft reset of the rate setting. A status output reports whether the card clock is running. Rate changes and stop requests wait for the end of the current output period, so the card never sees a shortened pulse. A soft reset leaves the clock running, so a reset sequence made of reset, reset-with-start and then several start writes keeps clocking the card throughout.

Top module: `cclk_gen`

## Requirements
- R1: After reset, `cardClk` is 0, `clkRunning` is 0, and the rate setting is the reset value 0x0001, which gives a ratio of 2.
- R2: The output period in peripheral clock cycles is `D+1` when `P` (rate bits [15:4]) is 0, and `(D+1)·2·P` otherwise, where `D` is rate bits [3:0].
- R3: When the ratio is even, `cardClk` is high for exactly half of the period. When the ratio is odd, it is high for `(D+1)/2` cycles, rounded down, and low for the rest.
- R4: A divider field of 0 behaves as a divider field of 1.
- R5: A control write with bit 1 (start) set while stopped raises `clkRunning` at that write's clock edge. `cardClk` rises on the following edge, starting with a full high phase.
- R6: A control write with bit 0 (stop) set takes effect at the end of the current output period. `clkRunning` clears at that edge, `cardClk` is low at that point and stays low afterwards. Stop wins over start when both bits are set in one write.
- R7: A rate write takes effect only at the next output period boundary, so the period in progress completes with the old ratio.
- R8: A control write with bit 3 (soft reset) set restores the rate setting to 0x0001 at the next period boundary and leaves the run state unchanged. A start bit in the same write is honoured.
- R9: `wrSel` 0 selects the control word and `wrSel` 1 selects the rate word. Nothing is written while `wrEn` is 0.
- R10: `cardClk` is 0 on every cycle that follows a cycle in which the clock is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrSel | input | 1 | 0 = control word, 1 = rate word |
| wrData | input | 16 | Write data |
| cardClk | output | 1 | Generated card bus clock |
| clkRunning | output | 1 | 1 while the card clock is running |

## Verification
Several properties are checked on every cycle:
- the divider counter stays within the active divider;
- the active rate changes only at a period boundary or a restart;
- the divider is never zero;
- the output is held low whenever the clock is not running;
- the running flag rises only after a start write, and falls only at a period end while the output is low.

The bench's scenarios are needed for the remaining behaviour:
- the exact high and low phase lengths for each rate;
- the behaviour of a rate change part-way through a period;
- the soft reset sequence keeping the clock alive;
- writes that are ignored.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  typedef struct packed {
    logic run;
    logic restart;
  } cclk_strobe_t;
endpackage

// File: rtl/cclk_ctrl.sv
module cclk_ctrl
  import cclk_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h0001,
  parameter int STOP_BIT = 0,
  parameter int START_BIT = 1,
  parameter int RST_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [RATE_W-1:0] wrData,
  input  logic              periodEnd,
  output logic [RATE_W-1:0] shadowRate,
  output cclk_strobe_t      strobe,
  output logic              running
);
  logic ctrlWr, rateWr, stopReq, startReq, rstReq, restart, stopPend;

  assign ctrlWr   = wrEn && !wrSel;
  assign rateWr   = wrEn && wrSel;
  assign stopReq  = ctrlWr && wrData[STOP_BIT];
  assign startReq = ctrlWr && wrData[START_BIT] && !stopReq;
  assign rstReq   = ctrlWr && wrData[RST_BIT];
  assign restart  = startReq && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadowRate <= RESET_RATE;
    else if (rateWr) shadowRate <= wrData;
    else if (rstReq) shadowRate <= RESET_RATE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
    end else begin
      if (restart) running <= 1'b1;
      else if (running && stopPend && periodEnd) running <= 1'b0;

      if (stopReq) stopPend <= running;
      else if (startReq) stopPend <= 1'b0;
      else if (periodEnd) stopPend <= 1'b0;
    end
  end

  assign strobe.run     = running;
  assign strobe.restart = restart;

  // R6
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(periodEnd));

  // R5
  start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(wrEn && !wrSel && wrData[START_BIT] && !wrData[STOP_BIT]));
endmodule

// File: rtl/cclk_datapath.sv
module cclk_datapath
  import cclk_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DIV_W = 4,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] shadowRate,
  input  cclk_strobe_t      strobe,
  output logic              cardClk,
  output logic              periodEnd
);
  localparam int PRE_W = RATE_W - DIV_W;
  localparam int CNT_W = PRE_W + 1;

  function automatic logic [DIV_W-1:0] clampDiv(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] actD, divCnt;
  logic [PRE_W-1:0] actP;
  logic [CNT_W-1:0] preCnt, preLimit;
  logic [DIV_W:0]   divPlus, half;
  logic             preLast, divLast, odd, highRaw;

  assign preLimit  = {actP, 1'b0} - CNT_W'(1);
  assign preLast   = (actP == '0) || (preCnt == preLimit);
  assign divLast   = (divCnt == actD);
  assign periodEnd = strobe.run && preLast && divLast;

  assign divPlus = {1'b0, actD} + (DIV_W+1)'(1);
  assign half    = divPlus >> 1;
  assign odd     = divPlus[0];
  assign highRaw = ({1'b0, divCnt} < half) ||
                   (odd && ({1'b0, divCnt} == half) && (preCnt < {1'b0, actP}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actD   <= clampDiv(RESET_RATE[DIV_W-1:0]);
      actP   <= RESET_RATE[RATE_W-1:DIV_W];
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobe.restart) begin
      actD   <= clampDiv(shadowRate[DIV_W-1:0]);
      actP   <= shadowRate[RATE_W-1:DIV_W];
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobe.run) begin
      if (preLast) begin
        preCnt <= '0;
        if (divLast) begin
          divCnt <= '0;
          actD   <= clampDiv(shadowRate[DIV_W-1:0]);
          actP   <= shadowRate[RATE_W-1:DIV_W];
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end else begin
        preCnt <= preCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cardClk <= 1'b0;
    else cardClk <= strobe.run && highRaw;
  end

  // R10
  low_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |=> !cardClk);

  // R2
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= actD);

  // R7
  rate_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({actD, actP}) |-> $past(strobe.restart || periodEnd));

  // R4
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    actD != '0);
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DIV_W = 4,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [RATE_W-1:0] wrData,
  output logic              cardClk,
  output logic              clkRunning
);
  cclk_strobe_t     strobe;
  logic [RATE_W-1:0] shadowRate;
  logic              periodEnd;

  cclk_ctrl #(.RATE_W(RATE_W), .RESET_RATE(RESET_RATE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .periodEnd(periodEnd), .shadowRate(shadowRate), .strobe(strobe),
    .running(clkRunning)
  );

  cclk_datapath #(.RATE_W(RATE_W), .DIV_W(DIV_W), .RESET_RATE(RESET_RATE)) dp_i (
    .clk(clk), .rst_n(rst_n), .shadowRate(shadowRate), .strobe(strobe),
    .cardClk(cardClk), .periodEnd(periodEnd)
  );

  // R6
  stop_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkRunning) |-> !cardClk);
endmodule

// File: tb/cclk_gen_tb_top.sv
module cclk_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic cardClk, clkRunning;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cardClk(cardClk), .clkRunning(clkRunning)
  );

  // {rate, high cycles, low cycles}
  localparam int NVEC = 11;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0001, 16'd1,     16'd1},     // R2 R3 fastest
    {16'h0002, 16'd1,     16'd2},     // R3 odd ratio 3
    {16'h0007, 16'd4,     16'd4},
    {16'h000E, 16'd7,     16'd8},     // R3 odd ratio 15
    {16'h000F, 16'd8,     16'd8},
    {16'h0011, 16'd2,     16'd2},     // R2 prescaler 1
    {16'h0012, 16'd3,     16'd3},
    {16'h0024, 16'd10,    16'd10},
    {16'h0000, 16'd1,     16'd1},     // R4 divider 0 as 1
    {16'h8001, 16'd4096,  16'd4096},
    {16'h800F, 16'd32768, 16'd32768}  // R2 slowest
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic countLevel(input logic lvl, output int n);
    n = 0;
    while (cardClk == lvl && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int hiExp, input int loExp, input string req);
    int hi, lo, guard;
    guard = 0;
    @(negedge clk);
    while (cardClk != 1'b1 && guard < 70000) begin guard++; @(negedge clk); end
    countLevel(1'b1, hi);
    countLevel(1'b0, lo);
    check(hi == hiExp, {req, " high"}, hi, hiExp);
    check(lo == loExp, {req, " low"}, lo, loExp);
  endtask

  task automatic stopClk();
    int guard;
    wr(1'b0, 16'h0001);
    guard = 0;
    @(negedge clk);
    while (clkRunning && guard < 70000) begin guard++; @(negedge clk); end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic prev;
    bit ok;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cardClk == 1'b0, "R1 cardClk", cardClk, 0);
    check(clkRunning == 1'b0, "R1 clkRunning", clkRunning, 0);

    // R5 start timing, R1 reset rate
    wr(1'b0, 16'h0002);
    @(negedge clk);
    check(clkRunning == 1'b1, "R5 running", clkRunning, 1);
    check(cardClk == 1'b0, "R5 first cycle low", cardClk, 0);
    @(negedge clk);
    check(cardClk == 1'b1, "R5 rise", cardClk, 1);
    measure(1, 1, "R1 reset rate");

    // table walk: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      stopClk();
      wr(1'b1, VEC[i][47:32]);
      wr(1'b0, 16'h0002);
      measure(int'(VEC[i][31:16]), int'(VEC[i][15:0]), $sformatf("R2 rate %h", VEC[i][47:32]));
    end

    // R6 stop at boundary, output low; stop wins over start
    stopClk();
    wr(1'b1, 16'h0007);
    wr(1'b0, 16'h0002);
    repeat (5) @(negedge clk);
    wr(1'b0, 16'h0003);
    prev = cardClk;
    n = 0;
    @(negedge clk);
    while (clkRunning && n < 20) begin prev = cardClk; n++; @(negedge clk); end
    check(!clkRunning, "R6 stopped", clkRunning, 0);
    check(!cardClk && !prev, "R6 low phase", cardClk, 0);
    ok = 1;
    repeat (20) begin @(negedge clk); if (cardClk) ok = 0; end
    check(ok, "R6 stays low", !ok, 0);

    // R7 rate change mid-period
    wr(1'b1, 16'h000F);
    wr(1'b0, 16'h0002);
    repeat (3) @(negedge clk);
    check(cardClk == 1'b1, "R7 in high phase", cardClk, 1);
    wr(1'b1, 16'h0001);
    @(negedge clk);
    while (cardClk) @(negedge clk);
    countLevel(1'b0, n);
    check(n == 8, "R7 old low phase", n, 8);
    countLevel(1'b1, n);
    check(n == 1, "R7 new high phase", n, 1);
    countLevel(1'b0, n);
    check(n == 1, "R7 new low phase", n, 1);

    // R8 soft reset sequence keeps clock running
    wr(1'b1, 16'h0007);
    ok = 1;
    wr(1'b0, 16'h0008);
    if (!clkRunning) ok = 0;
    wr(1'b0, 16'h000A);
    if (!clkRunning) ok = 0;
    for (int k = 0; k < 8; k++) begin
      wr(1'b0, 16'h0002);
      if (!clkRunning) ok = 0;
    end
    check(ok, "R8 running through reset", !ok, 0);
    measure(1, 1, "R8 rate restored");

    // R9 ignored writes
    @(posedge clk); #1;
    wrSel = 1'b0; wrData = 16'h0001; wrEn = 1'b0;
    repeat (30) @(negedge clk);
    wrData = '0;
    check(clkRunning == 1'b1, "R9 wrEn low ignored", clkRunning, 1);
    wr(1'b1, 16'h0001);
    repeat (10) @(negedge clk);
    check(clkRunning == 1'b1, "R9 rate select not control", clkRunning, 1);

    // R10 output quiet when stopped
    stopClk();
    ok = 1;
    repeat (40) begin @(negedge clk); if (cardClk) ok = 0; end
    check(ok, "R10 quiet", !ok, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule